// File: doc/BRIEF.md
# Four-Channel Zero-Safe PWM Generator

This block turns four 8-bit duty values into four pulse-width modulated enable signals for red, green, blue and white LED drivers. All four channels share one free-running period counter. Each channel has its own comparator and its own registered output pin.

The comparison is formed in its inverted sense: the logic detects when the counter has reached or passed the duty value, and the pin is the complement of that result. A duty of zero therefore gives a pin that stays low for the whole period, with no one-count spike. The cost is that the highest duty is 254 of 255 counts.

Duty values arrive from upstream registers. They take effect only at the start of a period, so a period that is already running is never cut short. A tick-enable input sets the counting rate, which lets a slower PWM frequency come from an upstream divider.

Top module: `lpwm_quad`

## Requirements
- R1: While rst_n is low at a rising clock edge, every pwm_out bit is 0 after that edge. After rst_n goes high, all outputs stay low for the first full period, because the duty copies in use start at 0.
- R2: The shared counter starts at 0 after reset. It steps by one on each rising edge where tick_en is high, and it wraps from 254 to 0, so one period is 255 ticks.
- R3: pwm_out[k] is a register. It is high in the cycle after an edge at which the counter was below the duty value channel k was using, and low otherwise.
- R4: A channel using duty 0 keeps its output low for the whole period, with no pulse at any count.
- R5: A duty input of 255 is clamped to 254. Such a channel is high for 254 of every 255 ticks, and no channel is ever high in the cycle after the counter stood at 254.
- R6: The duty value a channel uses is copied from duty_in only at the edge where tick_en is high and the counter stands at 254, that is at the wrap. A change to duty_in at any other time has no effect until the next wrap.
- R7: While tick_en is low, the counter holds its value and every output keeps its level.
- R8: The channels are independent. Channel k takes its duty from duty_in[8k+7:8k] and drives pwm_out[k]. Channel 0 is red, 1 is green, 2 is blue and 3 is white.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Advances the period counter by one when high |
| duty_in | input | 32 | Four packed 8-bit duty values; channel k in bits [8k+7:8k] |
| pwm_out | output | 4 | Registered PWM outputs; bit k is channel k |

## Verification
The hardest behaviour to observe is the period boundary. There, a duty change must be taken at exactly the wrap edge and ignored one edge earlier, and this must also hold when tick_en is low at that edge. The bench keeps its own count of ticks since reset, so it always knows where the boundary lies without reading internal state. It sweeps all 256 duty values across the channels with distinct offsets, and then runs a long phase in which tick_en is irregular and duty_in changes on every cycle. That phase brings the wrap edge together with a held tick and with duty changes, both just before and just after the boundary. Fixed-duty windows of 255 cycles confirm the high counts at 0, 1, 128, 254 and the clamped 255.

// File: rtl/lpwm_pkg.sv
// Package lpwm_pkg
// Holds the default sizes shared by the quad PWM block and its parts.
// Assumes the duty width is at least 2 bits.
package lpwm_pkg;
    localparam int unsigned LPWM_CHANNELS = 4;
    localparam int unsigned LPWM_DUTY_W   = 8;
endpackage

// File: rtl/lpwm_counter.sv
// Module lpwm_counter
// Shared period counter. It steps from 0 to 2**W-2 on each enabled tick and
// then wraps, so a period has 2**W-1 ticks. wrap_o marks the tick at the last
// count, which is the edge where the next period begins.
// Assumes: a synchronous active-low reset and a tick_en that is valid at every edge.
module lpwm_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] CNT_MAX = {{(W-1){1'b1}}, 1'b0};

    logic [W-1:0] cnt_q;

    assign wrap_o = tick_en && (cnt_q == CNT_MAX);
    assign cnt_o  = cnt_q;

    // Advance the count on each tick and return to zero after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wrap_o) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);                                            // R2
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_q == CNT_MAX) |=> (cnt_q == '0));             // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));                                 // R7
endmodule

// File: rtl/lpwm_shadow.sv
// Module lpwm_shadow
// Per-channel copy of the duty value in use. It loads only when load_i is high,
// which is the wrap, and clamps a full-scale input to the largest count.
// Assumes: load_i lasts one cycle and is high only at a period boundary.
module lpwm_shadow #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] duty_i,
    output logic [W-1:0] duty_o
);
    localparam logic [W-1:0] DUTY_TOP = {{(W-1){1'b1}}, 1'b0};

    logic [W-1:0] duty_q;
    logic [W-1:0] duty_sat;

    // Clamp the full-scale code to the highest count that can be reached.
    always_comb begin
        duty_sat = (duty_i > DUTY_TOP) ? DUTY_TOP : duty_i;
    end

    // Take the new duty only at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
        end else if (load_i) begin
            duty_q <= duty_sat;
        end
    end

    assign duty_o = duty_q;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(duty_q));                                 // R6
    AST_SHADOW_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        duty_q <= DUTY_TOP);                                          // R5
endmodule

// File: rtl/lpwm_compare.sv
// Module lpwm_compare
// One channel's comparator and pin register. The logic first decides whether
// the count has reached the duty value, which is the inverted sense, and the
// pin is the complement of that. A duty of zero therefore can never give a pulse.
// Assumes: cnt_i never exceeds 2**W-2 and duty_i is already clamped.
module lpwm_compare #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] duty_i,
    output logic         pwm_o
);
    localparam logic [W-1:0] CNT_LAST = {{(W-1){1'b1}}, 1'b0};

    logic off_now;
    logic pwm_q;

    // Inverted comparison: true once the count has reached the duty value.
    always_comb begin
        off_now = (cnt_i >= duty_i);
    end

    // Register the pin so that no comparator hazard reaches the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= !off_now;
        end
    end

    assign pwm_o = pwm_q;

    AST_ZERO_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_i == '0) |=> !pwm_q);                                   // R4
    AST_LAST_COUNT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == CNT_LAST) |=> !pwm_q);                              // R5
endmodule

// File: rtl/lpwm_quad.sv
// Module lpwm_quad
// Top of the multi-channel PWM. One shared period counter feeds CH_N channels.
// Each channel holds its own duty copy and its own registered comparator.
// Assumes: duty_in is stable from upstream registers, and tick_en sets the rate.
module lpwm_quad
    import lpwm_pkg::*;
#(
    parameter int unsigned CH_N   = LPWM_CHANNELS,
    parameter int unsigned DUTY_W = LPWM_DUTY_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_en,
    input  logic [CH_N*DUTY_W-1:0]   duty_in,
    output logic [CH_N-1:0]          pwm_out
);
    logic [DUTY_W-1:0] cnt;
    logic              wrap;

    lpwm_counter #(.W(DUTY_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_o   (cnt),
        .wrap_o  (wrap)
    );

    for (genvar k = 0; k < CH_N; k++) begin : g_ch
        logic [DUTY_W-1:0] duty_use;

        lpwm_shadow #(.W(DUTY_W)) u_shadow (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (wrap),
            .duty_i (duty_in[k*DUTY_W +: DUTY_W]),
            .duty_o (duty_use)
        );

        lpwm_compare #(.W(DUTY_W)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_i  (cnt),
            .duty_i (duty_use),
            .pwm_o  (pwm_out[k])
        );
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0));                                  // R1
endmodule

// File: tb/tb_lpwm_quad.sv
// Bench for lpwm_quad. It keeps a tick model taken from the requirements and
// compares every output bit on every cycle.
module tb_lpwm_quad;
    localparam int CH = 4;
    localparam int W  = 8;
    localparam int LAST = 254;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick_en = 1'b0;
    logic [CH*W-1:0] duty_in = '0;
    logic [CH-1:0]   pwm_out;

    int n_vec = 0;
    int n_bad = 0;
    int m_cnt = 0;
    int m_sh [CH];
    logic [CH-1:0] exp_out;
    bit done = 1'b0;

    lpwm_quad dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .duty_in (duty_in),
        .pwm_out (pwm_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [CH-1:0] got, input logic [CH-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t got=%b exp=%b", req, $time, got, exp);
        end
    endtask

    // One cycle: drive inputs, predict from pre-edge model state, update model.
    task automatic step(input logic tk, input logic [CH*W-1:0] d, input string req);
        tick_en = tk;
        duty_in = d;
        for (int k = 0; k < CH; k++) exp_out[k] = (m_cnt < m_sh[k]);
        if (tk) begin
            if (m_cnt == LAST) begin
                for (int k = 0; k < CH; k++) begin
                    int v = int'(d[k*W +: W]);
                    m_sh[k] = (v > LAST) ? LAST : v;   // R5 clamp
                end
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, pwm_out, exp_out);
    endtask

    function automatic logic [CH*W-1:0] pack4(input int a, input int b, input int c, input int e);
        return {e[7:0], c[7:0], b[7:0], a[7:0]};
    endfunction

    initial begin : main
        logic [15:0] lfsr;
        int hi [CH];
        for (int k = 0; k < CH; k++) m_sh[k] = 0;

        // R1: outputs low during reset, even with a full duty applied
        duty_in = '1;
        tick_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 reset", pwm_out, 4'b0000);
        end
        rst_n = 1'b1;

        // R1/R6: first period stays low although the duty inputs are nonzero
        for (int i = 0; i < 255; i++) step(1'b1, pack4(200, 100, 50, 255), "R1 first period");

        // R3/R8: exhaustive duty sweep, each channel offset by 64 codes
        for (int d = 0; d < 256; d++) begin
            for (int i = 0; i < 255; i++)
                step(1'b1, pack4(d, (d + 64) % 256, (d + 128) % 256, (d + 192) % 256), "R3 R8 sweep");
        end

        // R4/R5: fixed duty, count the highs in the last 255-cycle window
        for (int set = 0; set < 2; set++) begin
            logic [CH*W-1:0] dv;
            int ex [CH];
            if (set == 0) begin
                dv = pack4(0, 255, 1, 128);
                ex = '{0, 254, 1, 128};
            end else begin
                dv = pack4(254, 0, 255, 7);
                ex = '{254, 0, 254, 7};
            end
            for (int i = 0; i < 510; i++) step(1'b1, dv, "R3 settle");
            for (int k = 0; k < CH; k++) hi[k] = 0;
            for (int i = 0; i < 255; i++) begin
                step(1'b1, dv, "R3 window");
                for (int k = 0; k < CH; k++) hi[k] += int'(pwm_out[k]);
            end
            for (int k = 0; k < CH; k++) begin
                n_vec++;
                if (hi[k] != ex[k]) begin
                    n_bad++;
                    $display("FAIL R4 R5 ch%0d high count got=%0d exp=%0d", k, hi[k], ex[k]);
                end
            end
        end

        // R6/R7: irregular tick_en, duty_in changing on every cycle
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3], {lfsr, lfsr[7:0] ^ lfsr[15:8], lfsr[11:4]},
                 "R6 R7 irregular tick");
        end

        // R7: tick held low for a long stretch keeps every pin level
        for (int i = 0; i < 300; i++) step(1'b0, pack4(9, 99, 199, 0), "R7 tick held");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired got=hang exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule